// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is a single channel of a general-purpose timer. A separate timebase produces the shared count value and a terminal-count strobe. The channel watches that count together with one bidirectional pin. Depending on its mode, the channel works in one of three ways. It can record the count when the pin changes. It can drive the pin when the count reaches a stored value. It can generate a pulse-width-modulated waveform whose duty value is double-buffered.

A timer-wide center-aligned control overrides the channel's own mode. The channel then produces a symmetric PWM waveform from the same duty value. Each channel owns a value register, a mode and edge/level field, a sticky event flag and an interrupt enable. Software writes the value and configuration through simple write strobes and clears the flag by writing a one.

The terminal-count strobe `wrap_i` is high during the last count of a period. A buffered duty value therefore takes effect from the first count of the next period.

Top module: `tmr_chan`

## Requirements
- R1: After reset, pin_o, pin_oe_o, flag_o and irq_o are 0 and val_o is 0. The channel is in capture mode with no edge selected.
- R2: Capture mode is selected when cfg bits 1:0 are 00. The pin passes through a two-flop synchronizer. A pin change that lands before a clock edge is recorded at the third edge counted from that one: val_o takes the cnt_i value present at that edge, and the flag is set. Cfg bits 3:2 select the trigger edges: 01 rising only, 10 falling only, 11 both, 00 none. Edges that are not selected change neither val_o nor the flag.
- R3: Compare mode is selected when cfg bits 1:0 are 01. At every edge where cnt_i equals val_o, the flag is set and the pin acts according to cfg bits 3:2. A value of 01 drives the pin to 0, 10 drives it to 1, 11 inverts it, and 00 leaves it unchanged.
- R4: Edge PWM is selected when cfg bit 1 is 1. At each edge, pin_o becomes (cnt_i < duty) XOR cfg bit 2, where cfg bit 2 = 1 selects low-true pulses. A duty of 0 keeps the pin at its inactive level for every count.
- R5: In either PWM form, a value written to val_o is held back. The active duty loads it only at an edge where wrap_i is high. In the other modes the active duty follows val_o.
- R6: When center_i is 1, the channel runs center-aligned PWM whatever its mode bits are. The pin is active while the count is below the duty. It therefore turns inactive at the match on the way up and active again below the match on the way down. A duty of 0 gives a constantly inactive output, and a duty above the top count gives a constantly active output.
- R7: The flag is set by a capture event, a compare match, or a PWM count equal to the duty. flag_clr_i clears it. If an event and a clear fall in the same cycle, the flag stays set.
- R8: irq_o is high exactly when the flag is set and the enable (cfg bit 4) is 1.
- R9: pin_oe_o is 0 in capture mode and 1 in compare and PWM modes. center_i = 1 forces it to 1.
- R10: If a capture event and a software write of the value register fall in the same cycle, the captured count is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CW | Shared count from the timebase |
| wrap_i | input | 1 | Terminal-count strobe, high in the last count of a period |
| center_i | input | 1 | Timer-wide center-aligned PWM select |
| wr_val_i | input | 1 | Write strobe for the value register |
| wdata_i | input | CW | Data for the value register |
| wr_cfg_i | input | 1 | Write strobe for the configuration |
| cfg_i | input | 5 | {enable, edge/level[1:0], mode[1:0]} |
| flag_clr_i | input | 1 | Write-1 clear of the event flag |
| pin_i | input | 1 | Pin input level |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt request |
| val_o | output | CW | Value register readback |

## Verification
The bench builds the channel with its defaults: a 16-bit count and a two-stage synchronizer. Because the bench drives the count directly rather than through a running counter, it can place any value at any edge. This reaches the duty-of-zero and duty-above-top cases, the all-ones count, and repeated matches on a held count in a handful of cycles. It can also align a capture exactly with a flag clear or a value write to exercise the same-cycle priorities.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          center_i,
  input  logic          wr_val_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          wr_cfg_i,
  input  logic [4:0]    cfg_i,
  input  logic          flag_clr_i,
  input  logic          pin_i,
  output logic          pin_o,
  output logic          pin_oe_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic [CW-1:0] val_o
);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [1:0]      mode_q, sel_q;
  logic            ie_q;
  logic [CW-1:0]   val_q, act_q;
  logic            pin_q, flag_q;

  wire pin_s   = sync_q[SYNC-1];
  wire is_cap  = !center_i && (mode_q == 2'b00);
  wire is_cmp  = !center_i && (mode_q == 2'b01);
  wire is_pwm  = center_i || mode_q[1];
  wire rise    = pin_s & ~prev_q;
  wire fall    = ~pin_s & prev_q;
  wire cap_evt = is_cap && ((sel_q[0] && rise) || (sel_q[1] && fall));
  wire cmp_hit = is_cmp && (cnt_i == val_q);
  wire pwm_hit = is_pwm && (cnt_i == act_q);
  wire evt     = cap_evt | cmp_hit | pwm_hit;
  wire pwm_lvl = (cnt_i < act_q) ^ sel_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      mode_q <= 2'b00;
      sel_q  <= 2'b00;
      ie_q   <= 1'b0;
      val_q  <= '0;
      act_q  <= '0;
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      prev_q <= pin_s;
      if (wr_cfg_i) {ie_q, sel_q, mode_q} <= cfg_i;
      if (cap_evt)       val_q <= cnt_i;
      else if (wr_val_i) val_q <= wdata_i;
      if (!is_pwm || wrap_i) act_q <= val_q;
      if (is_pwm) pin_q <= pwm_lvl;
      else if (cmp_hit) begin
        case (sel_q)
          2'b01:   pin_q <= 1'b0;
          2'b10:   pin_q <= 1'b1;
          2'b11:   pin_q <= ~pin_q;
          default: pin_q <= pin_q;
        endcase
      end
      if (evt)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = !is_cap;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ie_q;
  assign val_o    = val_q;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_i,
  input logic          wrap_i,
  input logic          flag_clr_i,
  input logic          pin_o,
  input logic          flag_o,
  input logic          irq_o,
  input logic [CW-1:0] val_q,
  input logic [CW-1:0] act_q,
  input logic          is_pwm,
  input logic          is_cmp,
  input logic [1:0]    sel_q,
  input logic          cap_evt,
  input logic          evt
);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !flag_clr_i |=> flag_o);

  assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_o);

  assert_duty_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_pwm && !wrap_i |=> $stable(act_q));

  assert_capture_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> val_q == $past(cnt_i));

  assert_compare_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp && sel_q == 2'b10 && cnt_i == val_q |=> pin_o);

  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_pwm && act_q == '0 |=> pin_o == $past(sel_q[0]));

endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wrap_i(wrap_i),
  .flag_clr_i(flag_clr_i), .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o),
  .val_q(val_q), .act_q(act_q), .is_pwm(is_pwm), .is_cmp(is_cmp),
  .sel_q(sel_q), .cap_evt(cap_evt), .evt(evt)
);

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic          wrap_i = 1'b0, center_i = 1'b0;
  logic          wr_val_i = 1'b0, wr_cfg_i = 1'b0, flag_clr_i = 1'b0, pin_i = 1'b0;
  logic [CW-1:0] wdata_i = '0;
  logic [4:0]    cfg_i = '0;
  logic          pin_o, pin_oe_o, flag_o, irq_o;
  logic [CW-1:0] val_o;

  always #2 clk = ~clk;

  tmr_chan #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wrap_i(wrap_i), .center_i(center_i),
    .wr_val_i(wr_val_i), .wdata_i(wdata_i), .wr_cfg_i(wr_cfg_i), .cfg_i(cfg_i),
    .flag_clr_i(flag_clr_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .flag_o(flag_o), .irq_o(irq_o), .val_o(val_o)
  );

  typedef struct { int req; int sig; int unsigned exp; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  string names [5] = '{"pin_o", "pin_oe_o", "flag_o", "irq_o", "val_o"};

  function automatic int unsigned sample(int s);
    case (s)
      0: return int'(pin_o);
      1: return int'(pin_oe_o);
      2: return int'(flag_o);
      3: return int'(irq_o);
      default: return int'(val_o);
    endcase
  endfunction

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (sample(it.sig) !== it.exp) begin
        errors++;
        $display("FAIL R%0d %s: actual=%0d expected=%0d",
                 it.req, names[it.sig], sample(it.sig), it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_v(int req, int sig, int unsigned v);
    item_t it;
    it.req = req; it.sig = sig; it.exp = v;
    q.push_back(it);
  endtask

  task automatic wcfg(bit ie, bit [1:0] sel, bit [1:0] mode);
    cfg_i = {ie, sel, mode}; wr_cfg_i = 1'b1; tick(); wr_cfg_i = 1'b0;
  endtask

  task automatic wval(int unsigned v);
    wdata_i = CW'(v); wr_val_i = 1'b1; tick(); wr_val_i = 1'b0;
  endtask

  task automatic clr();
    flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
  endtask

  task automatic set_cnt_tick(int unsigned c);
    cnt_i = CW'(c); tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    expect_v(1, 0, 0); expect_v(1, 1, 0); expect_v(1, 2, 0);
    expect_v(1, 3, 0); expect_v(1, 4, 0);

    // R2 rising edge capture, three edges after the pin change
    wcfg(1, 2'b01, 2'b00);
    pin_i = 1'b1;
    set_cnt_tick(10);
    set_cnt_tick(11);
    expect_v(2, 2, 0);
    set_cnt_tick(12);
    expect_v(2, 4, 12); expect_v(2, 2, 1);
    expect_v(8, 3, 1);                    // R8 irq with enable set
    clr();
    expect_v(7, 2, 0); expect_v(8, 3, 0); // R7 write-1 clear

    // R2 falling edge ignored in rising-only mode
    pin_i = 1'b0;
    set_cnt_tick(20); set_cnt_tick(21); set_cnt_tick(22); set_cnt_tick(23);
    expect_v(2, 4, 12); expect_v(2, 2, 0);

    // R2 falling-only mode: rise ignored, fall captured
    wcfg(1, 2'b10, 2'b00);
    pin_i = 1'b1;
    set_cnt_tick(25); set_cnt_tick(26); set_cnt_tick(27); set_cnt_tick(28);
    expect_v(2, 4, 12);
    pin_i = 1'b0;
    set_cnt_tick(30); set_cnt_tick(31); set_cnt_tick(32);
    expect_v(2, 4, 32); expect_v(2, 2, 1);
    clr();

    // R2 both edges
    wcfg(1, 2'b11, 2'b00);
    pin_i = 1'b1;
    set_cnt_tick(40); set_cnt_tick(41); set_cnt_tick(42);
    expect_v(2, 4, 42);
    clr();

    // R7 capture and clear in the same cycle: capture wins
    pin_i = 1'b0;
    set_cnt_tick(50); set_cnt_tick(51);
    flag_clr_i = 1'b1; set_cnt_tick(52); flag_clr_i = 1'b0;
    expect_v(7, 2, 1); expect_v(7, 4, 52);
    clr();

    // R10 capture and value write in the same cycle: capture stored
    pin_i = 1'b1;
    set_cnt_tick(60); set_cnt_tick(61);
    wdata_i = 16'd999; wr_val_i = 1'b1; set_cnt_tick(62); wr_val_i = 1'b0;
    expect_v(10, 4, 62);
    wval(777);
    expect_v(10, 4, 777);
    wcfg(0, 2'b11, 2'b00);
    expect_v(8, 3, 0); expect_v(8, 2, 1); // R8 flag set, enable off
    expect_v(9, 1, 0);                    // R9 capture mode input only
    clr();

    // R3 compare: set, clear, toggle, no action
    cnt_i = '0;
    wcfg(1, 2'b10, 2'b01);
    expect_v(9, 1, 1);
    set_cnt_tick(776);
    expect_v(3, 0, 0); expect_v(3, 2, 0);
    set_cnt_tick(777);
    expect_v(3, 0, 1); expect_v(3, 2, 1);
    cnt_i = '0; wcfg(1, 2'b01, 2'b01);
    set_cnt_tick(777);
    expect_v(3, 0, 0);
    cnt_i = '0; wcfg(1, 2'b11, 2'b01);
    set_cnt_tick(777);
    expect_v(3, 0, 1);
    set_cnt_tick(777);
    expect_v(3, 0, 0);
    cnt_i = '0; wcfg(1, 2'b00, 2'b01);
    clr();
    set_cnt_tick(777);
    expect_v(3, 0, 0); expect_v(3, 2, 1);
    cnt_i = '0;
    clr();

    // R4 edge PWM, high-true, duty 3
    wval(3);
    wcfg(0, 2'b00, 2'b10);
    expect_v(9, 1, 1);
    set_cnt_tick(0); expect_v(4, 0, 1);
    set_cnt_tick(2); expect_v(4, 0, 1);
    set_cnt_tick(3); expect_v(4, 0, 0); expect_v(7, 2, 1);
    set_cnt_tick(9); expect_v(4, 0, 0);

    // R5 new duty waits for the terminal count
    cnt_i = 16'd5;
    wval(8);
    set_cnt_tick(5); expect_v(5, 0, 0);
    wrap_i = 1'b1; set_cnt_tick(9); wrap_i = 1'b0;
    set_cnt_tick(5); expect_v(5, 0, 1);

    // R4 low-true polarity
    wcfg(0, 2'b01, 2'b10);
    set_cnt_tick(5); expect_v(4, 0, 0);
    set_cnt_tick(8); expect_v(4, 0, 1);

    // R4 duty zero: inactive level (1 when low-true) for every count
    wval(0);
    wrap_i = 1'b1; set_cnt_tick(9); wrap_i = 1'b0;
    set_cnt_tick(0); expect_v(4, 0, 1);
    set_cnt_tick(16'hFFFF); expect_v(4, 0, 1);

    // R6 center-aligned overrides capture mode; top count 6
    center_i = 1'b1;
    wcfg(0, 2'b00, 2'b00);
    expect_v(9, 1, 1);
    wval(4);
    wrap_i = 1'b1; set_cnt_tick(6); wrap_i = 1'b0;
    set_cnt_tick(2); expect_v(6, 0, 1);
    set_cnt_tick(4); expect_v(6, 0, 0);
    set_cnt_tick(6); expect_v(6, 0, 0);
    set_cnt_tick(3); expect_v(6, 0, 1);
    wval(7);
    wrap_i = 1'b1; set_cnt_tick(6); wrap_i = 1'b0;
    set_cnt_tick(6); expect_v(6, 0, 1);
    set_cnt_tick(0); expect_v(6, 0, 1);
    center_i = 1'b0;
    tick();
    expect_v(9, 1, 0);

    @(negedge clk); #1;
    done = 1;
    summary();
    $finish;
  end
endmodule